// File: doc/BRIEF.md
# Host Interrupt Priority Glue

This block sits between a 16-bit asynchronous processor bus and three interrupt sources. One of them is an external peripheral that can supply its own vector. The other two are internal video events, horizontal blank and vertical blank, which cannot supply a vector. The block encodes the highest pending source onto the processor's active-low three-bit priority lines. It then watches the bus for an interrupt acknowledge cycle.

During an acknowledge cycle the block checks the level the processor is acknowledging. If that level is the peripheral's, it drives an acknowledge strobe to the peripheral. The peripheral then places the vector on the data bus and terminates the cycle itself. If that level is one of the video events, the block has no path to the data bus. It asserts the valid-peripheral-address line instead, and the processor takes an autovector. A video request is held in a latch from its rising event until its acknowledge cycle ends. The latch clears when the address strobe is released.

All inputs are assumed to be synchronous to `clk`. The peripheral request is a level. The video inputs are edge-detected.

Top module: `host_irq_glue`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `ipl_n` is 3'b111, `per_iack_n` is 1 and `vpa_n` is 1.
- R2: The peripheral request `per_irq_n` is active low and sits at level 6. One clock edge after it is sampled low, `ipl_n` shows 3'b001 (the inverted level). One edge after it is sampled high again, with no other source pending, `ipl_n` shows 3'b111.
- R3: Horizontal blank is level 2. A rising `hblank` sets a pending request. `ipl_n` shows 3'b101 two edges after the rise is sampled, and it keeps showing that value after `hblank` falls.
- R4: Vertical blank is level 4, shown on `ipl_n` as 3'b011. When several sources are pending, the highest level is shown: 6 over 4 over 2. With nothing pending, `ipl_n` is 3'b111.
- R5: An acknowledge cycle is recognised only when `as_n` is 0, `fc` is 3'b111 and `addr_hi` (A19..A16) is 4'b1111. Any other combination asserts neither `per_iack_n` nor `vpa_n`.
- R6: In an acknowledge cycle, if `addr_lvl` (A3..A1) equals 6 and `ipl_n` is showing level 6, `per_iack_n` goes low on the next edge and `vpa_n` stays high.
- R7: In an acknowledge cycle, if `addr_lvl` equals the level `ipl_n` is showing and that level is 4 or 2, `vpa_n` goes low on the next edge and `per_iack_n` stays high. The two outputs are never low together.
- R8: If `addr_lvl` differs from the level being shown, or nothing is shown, the acknowledge cycle asserts neither output.
- R9: Once asserted, `per_iack_n` or `vpa_n` stays low while `as_n` stays low. It returns high on the first edge at which `as_n` is sampled high.
- R10: When an acknowledge cycle for a video level ends, that video request is cleared. `ipl_n` then drops to the next pending level one edge later. Any other pending video request is kept.
- R11: A video input held high after its request is cleared does not raise a new request. Only a fresh rising event does. A rise in the same cycle that a clear happens wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| per_irq_n | input | 1 | Vectored peripheral request, active low |
| hblank | input | 1 | Horizontal blank event (rising edge) |
| vblank | input | 1 | Vertical blank event (rising edge) |
| as_n | input | 1 | Bus address strobe, active low |
| fc | input | 3 | Processor function code |
| addr_hi | input | 4 | Address bits 19..16 |
| addr_lvl | input | 3 | Address bits 3..1, the acknowledged level |
| ipl_n | output | 3 | Inverted priority level to the processor |
| per_iack_n | output | 1 | Acknowledge strobe to the peripheral, active low |
| vpa_n | output | 1 | Autovector request to the processor, active low |

## Verification
Each result has a fixed latency:
- The peripheral level reaches `ipl_n` one edge after the input is sampled.
- A video event reaches `ipl_n` two edges after it is sampled, because it passes the edge latch first.
- Acknowledge outputs assert one edge after the acknowledge cycle is sampled, and they release one edge after the strobe is sampled high.
- A cleared video level leaves `ipl_n` one edge later still.

The bench drives inputs at the falling edge and advances a reference model once per rising edge, using the values sampled there. It compares all three outputs at the following falling edge. Every step is therefore checked exactly at the cycle the requirements give.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;

    localparam int LVL_W = 3;
    localparam int FC_W  = 3;
    localparam int AHI_W = 4;

    typedef enum logic [1:0] {
        ACK_IDLE = 2'd0,
        ACK_PER  = 2'd1,
        ACK_HB   = 2'd2,
        ACK_VB   = 2'd3
    } ack_e;

    typedef struct packed {
        logic per;
        logic vb;
        logic hb;
    } src_req_t;

    function automatic logic iack_hit(input logic as_n,
                                      input logic [FC_W-1:0] fc,
                                      input logic [AHI_W-1:0] ahi);
        return (!as_n) && (fc == {FC_W{1'b1}}) && (ahi == {AHI_W{1'b1}});
    endfunction

endpackage

// File: rtl/hirq_blank_latch.sv
module hirq_blank_latch (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic clr,
    output logic pend
);
    logic prev_q;
    logic pend_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= raw;
            if (raw && !prev_q)
                pend_q <= 1'b1;
            else if (clr)
                pend_q <= 1'b0;
        end
    end

    assign pend = pend_q;
endmodule

// File: rtl/hirq_level_enc.sv
module hirq_level_enc #(
    parameter int LVL_W = 3,
    parameter int NSRC  = 3,
    parameter logic [NSRC*LVL_W-1:0] SRC_LVLS = {3'd6, 3'd4, 3'd2}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  act,
    output logic [LVL_W-1:0] ipl_n
);
    logic [LVL_W-1:0] best;
    logic [LVL_W-1:0] ipl_q;

    always_comb begin
        best = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (act[i] && (SRC_LVLS[i*LVL_W +: LVL_W] > best))
                best = SRC_LVLS[i*LVL_W +: LVL_W];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ipl_q <= '1;
        else     ipl_q <= ~best;
    end

    assign ipl_n = ipl_q;
endmodule

// File: rtl/hirq_ack_router.sv
module hirq_ack_router
    import host_irq_pkg::*;
#(
    parameter int PER_LVL = 6,
    parameter int VB_LVL  = 4,
    parameter int HB_LVL  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             as_n,
    input  logic             iack,
    input  logic [LVL_W-1:0] addr_lvl,
    input  logic [LVL_W-1:0] shown_lvl,
    output ack_e             state,
    output logic             clr_hb,
    output logic             clr_vb
);
    ack_e st_q;
    ack_e pick;

    always_comb begin
        pick = ACK_IDLE;
        if (addr_lvl == shown_lvl) begin
            if (shown_lvl == LVL_W'(PER_LVL))     pick = ACK_PER;
            else if (shown_lvl == LVL_W'(VB_LVL)) pick = ACK_VB;
            else if (shown_lvl == LVL_W'(HB_LVL)) pick = ACK_HB;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= ACK_IDLE;
        else if (as_n)
            st_q <= ACK_IDLE;
        else if (st_q == ACK_IDLE && iack)
            st_q <= pick;
    end

    assign state  = st_q;
    assign clr_hb = as_n && (st_q == ACK_HB);
    assign clr_vb = as_n && (st_q == ACK_VB);
endmodule

// File: rtl/host_irq_glue.sv
module host_irq_glue
    import host_irq_pkg::*;
#(
    parameter int PER_LVL = 6,
    parameter int VB_LVL  = 4,
    parameter int HB_LVL  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             per_irq_n,
    input  logic             hblank,
    input  logic             vblank,
    input  logic             as_n,
    input  logic [FC_W-1:0]  fc,
    input  logic [AHI_W-1:0] addr_hi,
    input  logic [LVL_W-1:0] addr_lvl,
    output logic [LVL_W-1:0] ipl_n,
    output logic             per_iack_n,
    output logic             vpa_n
);
    localparam int NVID = 2;
    localparam int NSRC = NVID + 1;

    logic [NVID-1:0] vid_raw, vid_clr, vid_pend;
    src_req_t        req;
    ack_e            ack_st;
    logic            clr_hb, clr_vb;
    logic            iack;

    assign vid_raw = {vblank, hblank};
    assign vid_clr = {clr_vb, clr_hb};

    for (genvar g = 0; g < NVID; g++) begin : g_vid
        hirq_blank_latch u_latch (
            .clk  (clk),
            .rst  (rst),
            .raw  (vid_raw[g]),
            .clr  (vid_clr[g]),
            .pend (vid_pend[g])
        );
    end

    assign req.per = !per_irq_n;
    assign req.vb  = vid_pend[1];
    assign req.hb  = vid_pend[0];

    hirq_level_enc #(
        .LVL_W    (LVL_W),
        .NSRC     (NSRC),
        .SRC_LVLS ({LVL_W'(PER_LVL), LVL_W'(VB_LVL), LVL_W'(HB_LVL)})
    ) u_enc (
        .clk   (clk),
        .rst   (rst),
        .act   (req),
        .ipl_n (ipl_n)
    );

    assign iack = iack_hit(as_n, fc, addr_hi);

    hirq_ack_router #(
        .PER_LVL (PER_LVL),
        .VB_LVL  (VB_LVL),
        .HB_LVL  (HB_LVL)
    ) u_ack (
        .clk       (clk),
        .rst       (rst),
        .as_n      (as_n),
        .iack      (iack),
        .addr_lvl  (addr_lvl),
        .shown_lvl (~ipl_n),
        .state     (ack_st),
        .clr_hb    (clr_hb),
        .clr_vb    (clr_vb)
    );

    assign per_iack_n = (ack_st != ACK_PER);
    assign vpa_n      = !((ack_st == ACK_HB) || (ack_st == ACK_VB));
endmodule

// File: rtl/host_irq_glue_chk.sv
module host_irq_glue_chk #(
    parameter int PER_LVL = 6
) (
    input logic       clk,
    input logic       rst,
    input logic       as_n,
    input logic [2:0] fc,
    input logic [3:0] addr_hi,
    input logic [2:0] addr_lvl,
    input logic [2:0] ipl_n,
    input logic       per_iack_n,
    input logic       vpa_n
);
    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (ipl_n == 3'b111 && per_iack_n && vpa_n));

    assert_decode_R5: assert property (@(posedge clk) disable iff (rst)
        ($fell(per_iack_n) || $fell(vpa_n)) |->
            ($past(!as_n) && $past(fc) == 3'b111 && $past(addr_hi) == 4'hF));

    assert_per_level_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(per_iack_n) |->
            ($past(ipl_n) == ~3'(PER_LVL) && $past(addr_lvl) == 3'(PER_LVL)));

    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(!per_iack_n && !vpa_n));

    assert_match_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(vpa_n) |-> ($past(ipl_n) != 3'b111 && $past(addr_lvl) == ~$past(ipl_n)));

    assert_release_R9: assert property (@(posedge clk) disable iff (rst)
        as_n |=> (per_iack_n && vpa_n));
endmodule

bind host_irq_glue host_irq_glue_chk #(.PER_LVL(PER_LVL)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .as_n       (as_n),
    .fc         (fc),
    .addr_hi    (addr_hi),
    .addr_lvl   (addr_lvl),
    .ipl_n      (ipl_n),
    .per_iack_n (per_iack_n),
    .vpa_n      (vpa_n)
);

// File: tb/host_irq_glue_test.sv
module host_irq_glue_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       per_irq_n = 1'b1, hblank = 1'b0, vblank = 1'b0, as_n = 1'b1;
    logic [2:0] fc = 3'b000;
    logic [3:0] addr_hi = 4'h0;
    logic [2:0] addr_lvl = 3'd0;
    logic [2:0] ipl_n;
    logic       per_iack_n, vpa_n;

    int n_run = 0, n_fail = 0;

    // reference model state: 0 idle, 1 peripheral, 2 hblank, 3 vblank
    logic [2:0] m_ipl = 3'b111;
    logic       m_hbp = 0, m_vbp = 0, m_hprev = 0, m_vprev = 0;
    int         m_st = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    host_irq_glue uut (
        .clk(clk), .rst(rst), .per_irq_n(per_irq_n), .hblank(hblank),
        .vblank(vblank), .as_n(as_n), .fc(fc), .addr_hi(addr_hi),
        .addr_lvl(addr_lvl), .ipl_n(ipl_n), .per_iack_n(per_iack_n),
        .vpa_n(vpa_n)
    );

    function automatic logic [2:0] top_level(logic p, logic v, logic h);
        if (p) return 3'd6;
        if (v) return 3'd4;
        if (h) return 3'd2;
        return 3'd0;
    endfunction

    task automatic model_edge();
        logic [2:0] shown = ~m_ipl;
        logic old_h = m_hbp, old_v = m_vbp;
        logic hr, vr, ack;
        if (rst) begin
            m_ipl = 3'b111; m_hbp = 0; m_vbp = 0;
            m_hprev = 0; m_vprev = 0; m_st = 0;
            return;
        end
        hr = hblank && !m_hprev;
        vr = vblank && !m_vprev;
        m_hprev = hblank; m_vprev = vblank;
        ack = !as_n && fc == 3'b111 && addr_hi == 4'hF;
        if (as_n) begin
            if (m_st == 2) m_hbp = 0;
            if (m_st == 3) m_vbp = 0;
            m_st = 0;
        end else if (m_st == 0 && ack && addr_lvl == shown) begin
            m_st = (shown == 3'd6) ? 1 : (shown == 3'd4) ? 3 : (shown == 3'd2) ? 2 : 0;
        end
        if (hr) m_hbp = 1;
        if (vr) m_vbp = 1;
        m_ipl = ~top_level(!per_irq_n, old_v, old_h);
    endtask

    task automatic tick(string tag);
        logic ex_per, ex_vpa;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        ex_per = !(m_st == 1);
        ex_vpa = !(m_st == 2 || m_st == 3);
        n_run++;
        if (ipl_n !== m_ipl || per_iack_n !== ex_per || vpa_n !== ex_vpa) begin
            n_fail++;
            $display("FAIL %s: ipl_n=%b per_iack_n=%b vpa_n=%b expected %b %b %b",
                     tag, ipl_n, per_iack_n, vpa_n, m_ipl, ex_per, ex_vpa);
        end
    endtask

    task automatic bus(logic a, logic [2:0] f, logic [3:0] h, logic [2:0] l);
        as_n = a; fc = f; addr_hi = h; addr_lvl = l;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick("R1"); tick("R1");
        rst = 1'b0;
        tick("R1");
        // R2 peripheral level
        per_irq_n = 0; tick("R2");
        per_irq_n = 1; tick("R2"); tick("R2");
        // R3 hblank latched
        hblank = 1; tick("R3"); tick("R3");
        hblank = 0; tick("R3"); tick("R3");
        // R4 priority
        vblank = 1; tick("R4"); tick("R4");
        per_irq_n = 0; tick("R4");
        // R5 wrong function code
        bus(0, 3'b110, 4'hF, 3'd6); tick("R5"); tick("R5");
        bus(1, 3'b000, 4'h0, 3'd0); tick("R5");
        bus(0, 3'b111, 4'hE, 3'd6); tick("R5");
        bus(1, 3'b000, 4'h0, 3'd0); tick("R5");
        // R6 peripheral acknowledge, R9 release
        bus(0, 3'b111, 4'hF, 3'd6); tick("R6"); tick("R6"); tick("R9");
        bus(1, 3'b111, 4'hF, 3'd6); tick("R9");
        per_irq_n = 1; bus(1, 3'b000, 4'h0, 3'd0); tick("R4"); tick("R4");
        // R8 mismatch
        bus(0, 3'b111, 4'hF, 3'd2); tick("R8"); tick("R8");
        bus(1, 3'b000, 4'h0, 3'd0); tick("R8");
        // R7 video acknowledge level 4, R10 clear keeps hblank
        bus(0, 3'b111, 4'hF, 3'd4); tick("R7"); tick("R7");
        bus(1, 3'b000, 4'h0, 3'd0); tick("R10"); tick("R10"); tick("R10");
        // R11 vblank still high: no new request; ack level 2
        bus(0, 3'b111, 4'hF, 3'd2); tick("R7");
        bus(1, 3'b000, 4'h0, 3'd0); tick("R10"); tick("R11"); tick("R11");
        // R11 rise at same edge as clear
        hblank = 1; tick("R3"); tick("R3");
        hblank = 0; bus(0, 3'b111, 4'hF, 3'd2); tick("R7");
        hblank = 1; bus(1, 3'b000, 4'h0, 3'd0); tick("R11"); tick("R11"); tick("R11");
        hblank = 0; vblank = 0; tick("R11");
        // randomized traffic
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 15) == 0) per_irq_n = ~per_irq_n;
            if ($urandom_range(0, 9) == 0) hblank = ~hblank;
            if ($urandom_range(0, 19) == 0) vblank = ~vblank;
            if ($urandom_range(0, 3) == 0) begin
                as_n = ~as_n;
                fc = ($urandom_range(0, 3) != 0) ? 3'b111 : 3'($urandom);
                addr_hi = ($urandom_range(0, 3) != 0) ? 4'hF : 4'($urandom);
                addr_lvl = ($urandom_range(0, 2) != 0) ? ~ipl_n : 3'($urandom);
            end
            tick("R4");
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule